// File: doc/BRIEF.md
# Edge and Gated-Time Pulse Accumulator

This block counts activity on a single capture input. In event counting it adds one for every active edge of the chosen polarity. In gated-time counting it adds one for every tick of an externally supplied clock enable while the input is held at its active level. The count is either one 16-bit accumulator or two independent 8-bit accumulators. In the paired form the upper half counts the main capture input and the lower half counts an auxiliary input. Both asynchronous inputs are brought into the clock domain by a synchroniser chain before any edge is detected.

Two flag bits record an overflow and an input edge. Each flag, ANDed with its own enable, drives its own interrupt line. A small register port reads the flags and both count bytes. Normally a flag is cleared by writing a one to its bit. With the fast-clear option set, writes to the flag register have no effect, and any access to a count byte clears both flags instead.

The counting mode is held in a four-state register. The states are `ST_IDLE` (counting off), `ST_EVT16` (16-bit edge counting), `ST_GATE16` (16-bit gated-time counting) and `ST_PAIR8` (two 8-bit edge counters). At every clock the register loads the state the configuration selects, so each state can move to any other. Dropping the enable goes to `ST_IDLE`. Setting pair selects `ST_PAIR8`. Otherwise setting gated selects `ST_GATE16`, and any remaining enabled setting selects `ST_EVT16`. Self-transitions keep the current mode. A configuration change takes effect one clock later.

Top module: `pacc_top`

## Requirements
- R1: After reset the flag register reads 0, both count bytes read 0, and both interrupt outputs are low.
- R2: In 16-bit event counting the count rises by one for each rising edge of `cap_i` when `cfg_pol_i`=1, or each falling edge when `cfg_pol_i`=0. An edge is counted at the third rising clock edge after the input changes, because of the two-flop synchroniser.
- R3: In either 16-bit form, an increment from 0xFFFF gives 0x0000 and sets the overflow flag (bit 1).
- R4: In paired form the upper byte (address 1) counts active edges of `cap_i` and the lower byte (address 2) counts active edges of `aux_i`. A lower-byte wrap neither changes the upper byte nor sets any flag.
- R5: In paired form with hold off, an upper-byte wrap from 0xFF to 0x00 sets the overflow flag.
- R6: In paired form with `cfg_hold_i`=1, both bytes stop at 0xFF. An active `cap_i` edge while the upper byte is 0xFF sets the overflow flag.
- R7: In gated-time counting the count rises once per clock in which `tick_i`=1 and `cap_i` is at its active level. The active level is high when `cfg_pol_i`=1 and low when it is 0. Leaving the active level sets the edge flag (bit 0). Entering it does not.
- R8: In event and paired forms an active edge on `cap_i` sets the edge flag (bit 0).
- R9: The flag register is at address 0, with overflow at bit 1, edge at bit 0, and higher bits reading 0. With fast clear off, writing a one clears the matching flag and writing a zero leaves it unchanged.
- R10: With `cfg_fast_i`=1, writes to the flag register clear nothing. Any read or write of address 1 or 2 clears both flags.
- R11: When a flag is set and cleared in the same clock, it ends up set.
- R12: `irq_ovf_o` equals the overflow flag AND `ie_ovf_i`. `irq_edge_o` equals the edge flag AND `ie_edge_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_i | input | 1 | Main capture input: edge source, or gate in gated-time counting |
| aux_i | input | 1 | Auxiliary capture input for the lower byte in paired form |
| cfg_en_i | input | 1 | Counting enable |
| cfg_gated_i | input | 1 | 1 selects gated-time counting |
| cfg_pair_i | input | 1 | 1 selects two 8-bit counters |
| cfg_pol_i | input | 1 | Edge or gate polarity |
| cfg_hold_i | input | 1 | Saturate 8-bit counters at the maximum value |
| cfg_fast_i | input | 1 | Fast flag clearing by count access |
| tick_i | input | 1 | Prescaled clock enable for gated-time counting |
| ie_ovf_i | input | 1 | Overflow interrupt enable |
| ie_edge_i | input | 1 | Edge interrupt enable |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 2 | 0 flags, 1 upper count byte, 2 lower count byte |
| bus_wdata_i | input | HALF_W | Write data |
| bus_rdata_o | output | HALF_W | Read data for the addressed register |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_edge_o | output | 1 | Edge interrupt request |

## Verification
A wrong mode state or a missed carry shows up as a count byte that differs from the arithmetic edge or tick total at the next read. Such reads are made a few clocks after each burst. A wrong flag priority or clearing path shows up in the flag read and the interrupt lines during the clock right after the access. A lost wrap shows as a missing overflow bit together with a 0x0000 count, sampled one clock after the final tick.

// File: rtl/pacc_pkg.sv
package pacc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EVT16  = 2'd1,
        ST_GATE16 = 2'd2,
        ST_PAIR8  = 2'd3
    } acc_state_t;

    localparam logic [1:0] ADDR_FLAG   = 2'd0;
    localparam logic [1:0] ADDR_CNT_HI = 2'd1;
    localparam logic [1:0] ADDR_CNT_LO = 2'd2;

    localparam int FLG_EDGE_BIT = 0;
    localparam int FLG_OVF_BIT  = 1;
    localparam int FLG_W        = 2;

endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2,
    parameter int N      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], raw_i[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign lvl_o[g]  = chain[STAGES-1];
        assign rise_o[g] = chain[STAGES-1] & ~prev;
        assign fall_o[g] = ~chain[STAGES-1] & prev;
    end

endmodule

// File: rtl/pacc_half.sv
module pacc_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         sat_i,
    output logic [W-1:0] val_o,
    output logic         max_o
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    assign max_o = (val_o == MAXV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_o <= '0;
        end else if (inc_i && !(sat_i && max_o)) begin
            val_o <= val_o + 1'b1;
        end
    end

    // R6: a saturated half never leaves its maximum
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i && max_o) |=> max_o);

endmodule

// File: rtl/pacc_flags.sv
module pacc_flags
    import pacc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLG_W-1:0] set_i,
    input  logic             wr_i,
    input  logic [FLG_W-1:0] wbits_i,
    input  logic             fast_i,
    input  logic             hit_i,
    output logic [FLG_W-1:0] flags_o
);

    logic [FLG_W-1:0] clr;

    always_comb begin
        if (fast_i) begin
            clr = {FLG_W{hit_i}};
        end else if (wr_i) begin
            clr = wbits_i;
        end else begin
            clr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            flags_o <= (flags_o & ~clr) | set_i;
        end
    end

    // R11: a set in the same clock as a clear wins
    p_set_wins_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[FLG_OVF_BIT] |=> flags_o[FLG_OVF_BIT]);
    p_set_wins_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[FLG_EDGE_BIT] |=> flags_o[FLG_EDGE_BIT]);

    // R10: with fast clear, flag writes do not disturb the flags
    p_fast_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_i && !hit_i && set_i == '0) |=> flags_o == $past(flags_o));

    // R9: normal write-one clearing of the overflow flag
    p_w1c_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast_i && wr_i && wbits_i[FLG_OVF_BIT] && !set_i[FLG_OVF_BIT])
        |=> !flags_o[FLG_OVF_BIT]);

endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic              aux_i,
    input  logic              cfg_en_i,
    input  logic              cfg_gated_i,
    input  logic              cfg_pair_i,
    input  logic              cfg_pol_i,
    input  logic              cfg_hold_i,
    input  logic              cfg_fast_i,
    input  logic              tick_i,
    input  logic              ie_ovf_i,
    input  logic              ie_edge_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [HALF_W-1:0] bus_wdata_i,
    output logic [HALF_W-1:0] bus_rdata_o,
    output logic              irq_ovf_o,
    output logic              irq_edge_o
);

    localparam int CAP_IDX = 0;
    localparam int AUX_IDX = 1;

    acc_state_t state, state_nx;

    logic [1:0] s_lvl, s_rise, s_fall;
    logic act_cap, act_aux, trail_cap, gate_on;
    logic lo_inc, hi_inc, half_sat;
    logic lo_max, hi_max;
    logic [HALF_W-1:0] lo_val, hi_val;
    logic ovf_set, edge_set;
    logic [FLG_W-1:0] set_vec, flags;
    logic wr_flag, cnt_hit;
    logic unused_bits;

    pacc_sync #(.STAGES(SYNC_STAGES), .N(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({aux_i, cap_i}),
        .lvl_o (s_lvl),
        .rise_o(s_rise),
        .fall_o(s_fall)
    );

    assign act_cap   = cfg_pol_i ? s_rise[CAP_IDX] : s_fall[CAP_IDX];
    assign trail_cap = cfg_pol_i ? s_fall[CAP_IDX] : s_rise[CAP_IDX];
    assign act_aux   = cfg_pol_i ? s_rise[AUX_IDX] : s_fall[AUX_IDX];
    assign gate_on   = (s_lvl[CAP_IDX] == cfg_pol_i);

    // next mode chosen from configuration
    always_comb begin
        if (!cfg_en_i) begin
            state_nx = ST_IDLE;
        end else if (cfg_pair_i) begin
            state_nx = ST_PAIR8;
        end else if (cfg_gated_i) begin
            state_nx = ST_GATE16;
        end else begin
            state_nx = ST_EVT16;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // per-mode increment and flag-set decoding
    always_comb begin
        lo_inc   = 1'b0;
        hi_inc   = 1'b0;
        half_sat = 1'b0;
        ovf_set  = 1'b0;
        edge_set = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_EVT16: begin
                lo_inc   = act_cap;
                hi_inc   = act_cap & lo_max;
                ovf_set  = act_cap & lo_max & hi_max;
                edge_set = act_cap;
            end
            ST_GATE16: begin
                lo_inc   = tick_i & gate_on;
                hi_inc   = tick_i & gate_on & lo_max;
                ovf_set  = tick_i & gate_on & lo_max & hi_max;
                edge_set = trail_cap;
            end
            ST_PAIR8: begin
                lo_inc   = act_aux;
                hi_inc   = act_cap;
                half_sat = cfg_hold_i;
                ovf_set  = act_cap & hi_max;
                edge_set = act_cap;
            end
        endcase
    end

    pacc_half #(.W(HALF_W)) u_lo (
        .clk  (clk),
        .rst_n(rst_n),
        .inc_i(lo_inc),
        .sat_i(half_sat),
        .val_o(lo_val),
        .max_o(lo_max)
    );

    pacc_half #(.W(HALF_W)) u_hi (
        .clk  (clk),
        .rst_n(rst_n),
        .inc_i(hi_inc),
        .sat_i(half_sat),
        .val_o(hi_val),
        .max_o(hi_max)
    );

    assign wr_flag = bus_sel_i & bus_wr_i & (bus_addr_i == ADDR_FLAG);
    assign cnt_hit = bus_sel_i &
                     ((bus_addr_i == ADDR_CNT_HI) | (bus_addr_i == ADDR_CNT_LO));

    always_comb begin
        set_vec               = '0;
        set_vec[FLG_OVF_BIT]  = ovf_set;
        set_vec[FLG_EDGE_BIT] = edge_set;
    end

    pacc_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .wr_i   (wr_flag),
        .wbits_i(bus_wdata_i[FLG_W-1:0]),
        .fast_i (cfg_fast_i),
        .hit_i  (cnt_hit),
        .flags_o(flags)
    );

    assign unused_bits = ^{bus_wdata_i[HALF_W-1:FLG_W], s_lvl[AUX_IDX]};

    always_comb begin
        unique case (bus_addr_i)
            ADDR_FLAG:   bus_rdata_o = {{(HALF_W-FLG_W){1'b0}}, flags};
            ADDR_CNT_HI: bus_rdata_o = hi_val;
            ADDR_CNT_LO: bus_rdata_o = lo_val;
            default:     bus_rdata_o = '0;
        endcase
    end

    assign irq_ovf_o  = flags[FLG_OVF_BIT] & ie_ovf_i;
    assign irq_edge_o = flags[FLG_EDGE_BIT] & ie_edge_i;

    // R3: a 16-bit wrap raises the overflow flag
    p_wrap16_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_EVT16 || state == ST_GATE16) && lo_inc && lo_max && hi_max)
        |=> flags[FLG_OVF_BIT]);

    // R4: no carry between halves in paired form
    p_pair_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAIR8 && lo_inc && lo_max && !hi_inc)
        |=> hi_val == $past(hi_val));

    // R8: an active edge in event or paired form sets the edge flag
    p_edge_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_EVT16 || state == ST_PAIR8) && act_cap)
        |=> flags[FLG_EDGE_BIT]);

    // R1: counting stays frozen while idle
    p_idle_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> ($stable(lo_val) && $stable(hi_val)));

endmodule

// File: tb/tb_pacc_top.sv
`timescale 1ns/1ps
module tb_pacc_top;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_i = 0, aux_i = 0;
    logic cfg_en_i = 0, cfg_gated_i = 0, cfg_pair_i = 0, cfg_pol_i = 1;
    logic cfg_hold_i = 0, cfg_fast_i = 0, tick_i = 0;
    logic ie_ovf_i = 0, ie_edge_i = 0;
    logic bus_sel_i = 0, bus_wr_i = 0;
    logic [1:0] bus_addr_i = 0;
    logic [W-1:0] bus_wdata_i = 0;
    logic [W-1:0] bus_rdata_o;
    logic irq_ovf_o, irq_edge_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pacc_top #(.HALF_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_i), .aux_i(aux_i),
        .cfg_en_i(cfg_en_i), .cfg_gated_i(cfg_gated_i), .cfg_pair_i(cfg_pair_i),
        .cfg_pol_i(cfg_pol_i), .cfg_hold_i(cfg_hold_i), .cfg_fast_i(cfg_fast_i),
        .tick_i(tick_i), .ie_ovf_i(ie_ovf_i), .ie_edge_i(ie_edge_i),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .irq_ovf_o(irq_ovf_o), .irq_edge_o(irq_edge_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
        #1 v = int'(bus_rdata_o);
        @(negedge clk);
        bus_sel_i = 0;
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = W'(d);
        @(negedge clk);
        bus_sel_i = 0; bus_wr_i = 0;
    endtask

    task automatic rd16(output int v);
        int h, l;
        rd(2'd1, h);
        rd(2'd2, l);
        v = (h << 8) | l;
    endtask

    task automatic pulse(input bit on_cap, input bit on_aux, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap_i = on_cap; aux_i = on_aux;
            repeat (2) @(negedge clk);
            cap_i = 0; aux_i = 0;
            repeat (1) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        tick_i = 1;
        repeat (k) @(negedge clk);
        tick_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        cap_i = 0; aux_i = 0; tick_i = 0;
        cfg_en_i = 0; cfg_gated_i = 0; cfg_pair_i = 0; cfg_pol_i = 1;
        cfg_hold_i = 0; cfg_fast_i = 0; ie_ovf_i = 0; ie_edge_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int v, total;
        do_reset();

        // R1 reset state
        rd(2'd0, v); check("R1 flags", v, 0);
        rd(2'd1, v); check("R1 count hi", v, 0);
        rd(2'd2, v); check("R1 count lo", v, 0);
        check("R1 irq_ovf", int'(irq_ovf_o), 0);
        check("R1 irq_edge", int'(irq_edge_o), 0);

        // R2 16-bit event counting, rising then falling polarity
        cfg_en_i = 1; repeat (2) @(negedge clk);
        total = 0;
        for (int n = 1; n <= 9; n += 4) begin
            pulse(1, 0, n);
            total += n;
            rd16(v); check("R2 rising count", v, total);
        end
        cfg_pol_i = 0; repeat (2) @(negedge clk);
        pulse(1, 0, 5); total += 5;
        rd16(v); check("R2 falling count", v, total);

        // R8 edge flag, R12 interrupt gating, R9 clearing
        rd(2'd0, v); check("R8 edge flag set", v, 1);
        @(negedge clk); ie_edge_i = 1; #1 check("R12 irq_edge on", int'(irq_edge_o), 1);
        @(negedge clk); ie_edge_i = 0; #1 check("R12 irq_edge masked", int'(irq_edge_o), 0);
        wr(2'd0, 8'hFC);
        rd(2'd0, v); check("R9 zero write keeps flag", v, 1);
        wr(2'd0, 1);
        rd(2'd0, v); check("R9 write one clears", v, 0);

        // R11 set and clear in the same clock
        cfg_pol_i = 1; repeat (2) @(negedge clk);
        @(negedge clk); cap_i = 1;
        @(negedge clk);
        @(negedge clk);
        bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = 2'd0; bus_wdata_i = 8'h01;
        @(negedge clk);
        bus_sel_i = 0; bus_wr_i = 0;
        cap_i = 0;
        rd(2'd0, v); check("R11 set beats clear", v, 1);
        total += 1;
        repeat (4) @(negedge clk);
        rd16(v); check("R2 count after coincidence", v, total);

        // R7 gated-time counting
        do_reset();
        cfg_en_i = 1; cfg_gated_i = 1; cfg_pol_i = 1;
        cap_i = 1; repeat (4) @(negedge clk);
        ticks(37);
        rd16(v); check("R7 gated count", v, 37);
        rd(2'd0, v); check("R7 leading gate edge no flag", v, 0);
        cap_i = 0; repeat (4) @(negedge clk);
        rd(2'd0, v); check("R7 trailing edge flag", v, 1);
        ticks(20);
        rd16(v); check("R7 inactive gate holds", v, 37);
        wr(2'd0, 1);
        cfg_pol_i = 0; repeat (2) @(negedge clk);
        ticks(5);
        rd16(v); check("R7 active-low gate count", v, 42);
        cap_i = 1; repeat (4) @(negedge clk);
        rd(2'd0, v); check("R7 active-low trailing flag", v, 1);

        // R3 16-bit wrap
        do_reset();
        cfg_en_i = 1; cfg_gated_i = 1; cfg_pol_i = 1;
        cap_i = 1; repeat (4) @(negedge clk);
        ticks(65535);
        rd16(v); check("R3 count at max", v, 16'hFFFF);
        rd(2'd0, v); check("R3 no flag before wrap", v, 0);
        ticks(1);
        rd16(v); check("R3 wrapped count", v, 0);
        rd(2'd0, v); check("R3 overflow flag", v, 2);
        @(negedge clk); ie_ovf_i = 1; #1 check("R12 irq_ovf on", int'(irq_ovf_o), 1);
        wr(2'd0, 2);
        rd(2'd0, v); check("R9 overflow cleared", v, 0);
        check("R12 irq_ovf after clear", int'(irq_ovf_o), 0);

        // R4 and R5 paired counters
        do_reset();
        cfg_en_i = 1; cfg_pair_i = 1; repeat (2) @(negedge clk);
        pulse(1, 0, 10);
        pulse(0, 1, 3);
        rd(2'd1, v); check("R4 upper count", v, 10);
        rd(2'd2, v); check("R4 lower count", v, 3);
        pulse(0, 1, 256);
        rd(2'd2, v); check("R4 lower wrapped", v, 3);
        rd(2'd1, v); check("R4 no carry", v, 10);
        rd(2'd0, v); check("R4 no overflow from lower", v, 1);
        pulse(1, 0, 245);
        rd(2'd1, v); check("R5 upper at max", v, 255);
        rd(2'd0, v); check("R5 no overflow yet", v, 1);
        pulse(1, 0, 1);
        rd(2'd1, v); check("R5 upper wrapped", v, 0);
        rd(2'd0, v); check("R5 overflow flag", v, 3);

        // R6 saturating halves
        do_reset();
        cfg_en_i = 1; cfg_pair_i = 1; cfg_hold_i = 1; repeat (2) @(negedge clk);
        pulse(1, 1, 255);
        rd(2'd0, v); check("R6 no overflow at max", v, 1);
        pulse(1, 1, 3);
        rd(2'd1, v); check("R6 upper held", v, 255);
        rd(2'd2, v); check("R6 lower held", v, 255);
        rd(2'd0, v); check("R6 overflow on held edge", v, 3);

        // R10 fast clearing
        cfg_fast_i = 1;
        wr(2'd0, 3);
        rd(2'd0, v); check("R10 flag write ignored", v, 3);
        rd(2'd1, v);
        rd(2'd0, v); check("R10 count read clears", v, 0);
        pulse(1, 0, 1);
        rd(2'd0, v); check("R10 flags set again", v, 3);
        wr(2'd2, 0);
        rd(2'd0, v); check("R10 count write clears", v, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule